// File: doc/BRIEF.md
# Multi-driver four-state net resolver

This block computes the value seen on a single shared net that several four-state drivers hold at once. Each driver presents one of four levels: strong 0, strong 1, high impedance (Z) or unknown (X). The block combines them with bus-collision rules. Undriven (Z) contributions drop out, opposing strong levels collide to X, and any unknown driver makes the whole net unknown.

A mode input adds a weak pull to 1. When it is asserted, a net that every driver leaves floating reads as 1 instead of Z, and every other result passes through unchanged. The block is purely combinational, so the output follows its inputs within the same cycle. It is meant for behavioural models of shared buses and for checking tri-state wiring.

Top module: `net_resolver`

## Requirements
- R1: Levels on every driver and on the output use a 2-bit code: 2'b00 = 0, 2'b01 = 1, 2'b10 = Z, 2'b11 = X. The driver count N is a parameter from 1 to 16, and driver k occupies `drv_i[k]`.
- R2: The output is 0 when at least one driver is 0 and no driver is 1 or X. Any number of Z drivers do not change this.
- R3: The output is 1 when at least one driver is 1 and no driver is 0 or X. Any number of Z drivers do not change this.
- R4: With the pullup off, the output is Z exactly when all N drivers are Z.
- R5: When at least one driver is 0, at least one is 1 and none is X, the output is X.
- R6: When any driver is X, the output is X whatever the other drivers and the pullup mode are.
- R7: With `pullup_en_i` high, the output is never Z. An all-Z net reads 1.
- R8: With `pullup_en_i` high, every non-floating result equals the result with the pullup off.
- R9: The output depends only on how many drivers carry each level, not on which driver positions carry them. It settles in the same cycle as the inputs change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| drv_i | input | N x 2 | Packed array of driver levels, one 2-bit code per driver |
| pullup_en_i | input | 1 | Weak pull-to-1 mode: a floating net reads 1 |
| net_o | output | 2 | Resolved net level |

## Verification
The assertions check on every evaluation that an X driver always yields X, that a pulled-up net never floats, and that a resolved 0, 1 or Z is consistent with the drivers present. Each is checked against flags the checker counts itself. Order independence, the exact value under a collision, and the rule that the pullup leaves non-floating results unchanged are shown by the bench. The bench runs an exhaustive sweep of all driver combinations in both modes, plus directed permutations of the same driver set.

// File: rtl/net_res_pkg.sv
package net_res_pkg;
  typedef enum logic [1:0] {
    LVL_0 = 2'b00,
    LVL_1 = 2'b01,
    LVL_Z = 2'b10,
    LVL_X = 2'b11
  } lvl_e;

  typedef struct packed {
    logic has0;
    logic has1;
    logic hasx;
  } net_flags_t;
endpackage

// File: rtl/net_res_flags.sv
module net_res_flags
  import net_res_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0][1:0] drv_i,
  output net_flags_t        flags_o
);
  logic [N-1:0] is0, is1, isx;

  // per-driver one-hot decode; Z sets nothing
  for (genvar k = 0; k < N; k++) begin : g_dec
    assign is0[k] = (drv_i[k] == LVL_0);
    assign is1[k] = (drv_i[k] == LVL_1);
    assign isx[k] = (drv_i[k] == LVL_X);
  end

  assign flags_o.has0 = |is0;
  assign flags_o.has1 = |is1;
  assign flags_o.hasx = |isx;
endmodule

// File: rtl/net_res_rule.sv
module net_res_rule
  import net_res_pkg::*;
(
  input  net_flags_t flags_i,
  input  logic       pullup_en_i,
  output logic [1:0] net_o
);
  lvl_e lvl;

  // priority: X, collision, 0, 1, float
  always_comb begin
    if (flags_i.hasx)                       lvl = LVL_X;
    else if (flags_i.has0 && flags_i.has1)  lvl = LVL_X;
    else if (flags_i.has0)                  lvl = LVL_0;
    else if (flags_i.has1)                  lvl = LVL_1;
    else if (pullup_en_i)                   lvl = LVL_1;
    else                                    lvl = LVL_Z;
  end

  assign net_o = lvl;
endmodule

// File: rtl/net_resolver.sv
module net_resolver
  import net_res_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0][1:0] drv_i,
  input  logic              pullup_en_i,
  output logic [1:0]        net_o
);
  net_flags_t flags;

  net_res_flags #(.N(N)) i_flags (
    .drv_i   (drv_i),
    .flags_o (flags)
  );

  net_res_rule i_rule (
    .flags_i     (flags),
    .pullup_en_i (pullup_en_i),
    .net_o       (net_o)
  );
endmodule

// File: rtl/net_resolver_chk.sv
module net_resolver_chk #(
  parameter int N = 4
) (
  input logic [N-1:0][1:0] drv_i,
  input logic              pullup_en_i,
  input logic [1:0]        net_o
);
  int n0, n1, nz, nx;

  always_comb begin
    n0 = 0; n1 = 0; nz = 0; nx = 0;
    for (int k = 0; k < N; k++) begin
      case (drv_i[k])
        2'b00:   n0++;
        2'b01:   n1++;
        2'b10:   nz++;
        default: nx++;
      endcase
    end
  end

  always_comb begin
    p_x_poisons_r6: assert (nx == 0 || net_o == 2'b11)
      else $error("X driver did not poison net");
    p_no_float_pullup_r7: assert (!pullup_en_i || net_o != 2'b10)
      else $error("net floats with pullup on");
    p_float_only_all_z_r4: assert (net_o != 2'b10 || (nz == N && !pullup_en_i))
      else $error("Z output with a driving source");
    p_zero_clean_r2: assert (net_o != 2'b00 || (n0 > 0 && n1 == 0 && nx == 0))
      else $error("0 output inconsistent");
    p_one_clean_r3: assert (net_o != 2'b01 || (nx == 0 && n0 == 0 && (n1 > 0 || pullup_en_i)))
      else $error("1 output inconsistent");
    p_collide_r5: assert (!(n0 > 0 && n1 > 0) || net_o == 2'b11)
      else $error("collision not X");
  end
endmodule

bind net_resolver net_resolver_chk #(.N(N)) i_chk (
  .drv_i       (drv_i),
  .pullup_en_i (pullup_en_i),
  .net_o       (net_o)
);

// File: tb/test_net_resolver.sv
module test_net_resolver;
  localparam int N = 4;
  localparam int SWEEP_BITS = (2 * N > 12) ? 12 : 2 * N;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0][1:0] drv;
  logic pullup_en;
  logic [1:0] net;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  net_resolver #(.N(N)) i_net_resolver (
    .drv_i       (drv),
    .pullup_en_i (pullup_en),
    .net_o       (net)
  );

  // behavioural model: count levels, apply rules
  function automatic logic [1:0] model(input logic [N-1:0][1:0] d, input logic pu,
                                       output string req);
    int c0 = 0, c1 = 0, cx = 0;
    for (int k = 0; k < N; k++) begin
      if (d[k] == 2'b00) c0++;
      else if (d[k] == 2'b01) c1++;
      else if (d[k] == 2'b11) cx++;
    end
    if (cx > 0)                begin req = "R6"; return 2'b11; end
    if (c0 > 0 && c1 > 0)      begin req = "R5"; return 2'b11; end
    if (c0 > 0)                begin req = pu ? "R8" : "R2"; return 2'b00; end
    if (c1 > 0)                begin req = pu ? "R8" : "R3"; return 2'b01; end
    if (pu)                    begin req = "R7"; return 2'b01; end
    req = "R4";
    return 2'b10;
  endfunction

  task automatic apply(input logic [N-1:0][1:0] d, input logic pu, input string tag);
    string req;
    logic [1:0] exp;
    @(posedge clk);
    drv = d;
    pullup_en = pu;
    @(negedge clk);
    exp = model(d, pu, req);
    if (tag != "") req = tag;
    n_run++;
    if (net !== exp) begin
      n_fail++;
      $display("FAIL %s drv=%b pu=%b got=%b exp=%b", req, d, pu, net, exp);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    drv = '{default: 2'b10};
    pullup_en = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // reset state: all floating, no pullup (R1, R4)
    @(negedge clk);
    n_run++;
    if (net !== 2'b10) begin
      n_fail++;
      $display("FAIL R4 idle got=%b exp=10", net);
    end
    // directed, R1 encoding via model
    apply('{2'b10, 2'b10, 2'b00, 2'b10}, 1'b0, "R2");
    apply('{2'b10, 2'b01, 2'b10, 2'b10}, 1'b0, "R3");
    apply('{2'b00, 2'b00, 2'b00, 2'b00}, 1'b0, "R2");
    apply('{2'b01, 2'b10, 2'b10, 2'b00}, 1'b0, "R5");
    apply('{2'b11, 2'b10, 2'b10, 2'b10}, 1'b1, "R6");
    apply('{2'b10, 2'b10, 2'b10, 2'b10}, 1'b1, "R7");
    apply('{2'b00, 2'b10, 2'b10, 2'b10}, 1'b1, "R8");
    apply('{2'b01, 2'b00, 2'b01, 2'b10}, 1'b1, "R8");
    apply('{2'b01, 2'b01, 2'b01, 2'b11}, 1'b0, "R6");
    // permutations of one driver set (R9)
    apply('{2'b00, 2'b10, 2'b10, 2'b10}, 1'b0, "R9");
    apply('{2'b10, 2'b00, 2'b10, 2'b10}, 1'b0, "R9");
    apply('{2'b10, 2'b10, 2'b10, 2'b00}, 1'b0, "R9");
    apply('{2'b10, 2'b11, 2'b01, 2'b10}, 1'b0, "R9");
    apply('{2'b01, 2'b10, 2'b10, 2'b11}, 1'b0, "R9");
    // exhaustive sweep in both modes, R1 through R8
    for (int pu = 0; pu < 2; pu++) begin
      for (int v = 0; v < (1 << SWEEP_BITS); v++) begin
        logic [N-1:0][1:0] d;
        d = '{default: 2'b10};
        for (int b = 0; b < SWEEP_BITS; b++) d[b/2][b%2] = v[b];
        apply(d, pu[0], "");
      end
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule